// File: doc/BRIEF.md
# HDLC Frame Transmitter with Programmable Opening Flags

This block serializes HDLC frames onto a single transmit data line, one bit per clock cycle. A host presents the frame's bytes on a valid/ready byte interface. Each byte carries a marker for the end of its buffer and a marker for the end of the frame. When the line is idle and a byte is offered, the block raises its request-to-send output and waits for clear-to-send. It then sends the mandatory opening flag plus a configurable number of extra flags. After the flags it sends the frame bytes (address, control, information) with zero-bit insertion. It closes with the complemented CRC-16/CCITT and a closing flag, and then releases the line.

Each time the final bit of a byte marked as the end of a buffer leaves on the line, a one-cycle transmit-buffer event is raised. This tells the host that the whole buffer has been shifted out, not merely accepted.

Top module: `hdlc_tx`

## Requirements
- R1: Each frame starts with 1 + `cfg_extra_flags` flag bytes 0x7E, sent least significant bit first (line sequence 0,1,1,1,1,1,1,0).
- R2: Frame bytes are sent least significant bit first, in the order accepted. The byte accepted with `in_eof` high is the last one before the CRC. The CRC is followed by one closing flag.
- R3: `txb_evt` is high for exactly one cycle: the cycle in which the last data bit of a byte accepted with `in_last` (or `in_eof`) is on `txd`. It is low at every other time.
- R4: `rts` rises one cycle after `in_valid` is seen while idle. No flag bit appears while `cts` is low. The first flag bit appears on `txd` in the second cycle after the one in which `cts` is first driven high.
- R5: Within the byte and CRC fields, a 0 is inserted after every five consecutive 1 bits. This includes a run that ends the CRC right before the closing flag.
- R6: Flag bits are never stuffed, and flags reset the run of ones.
- R7: The CRC uses the reflected polynomial 0x8408 with preset 0xFFFF over all frame bits. Its ones' complement is sent least significant bit first. The check value over the ASCII string "123456789" is 0x906E.
- R8: `txd` is 1 whenever no frame is being sent. `txd` is 1 and `rts` is still high in the cycle after the last closing-flag bit. `rts` is low in the cycle after that.
- R9: `in_ready` is high for exactly one cycle per accepted byte, in the cycle before that byte's first bit may be sent. The byte is taken at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_extra_flags | input | XF_W (4) | Extra opening flags beyond the required one |
| in_valid | input | 1 | A frame byte is offered |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte ends its buffer |
| in_eof | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Byte is taken at this clock edge |
| cts | input | 1 | Clear to send |
| rts | output | 1 | Request to send |
| txd | output | 1 | Serial line, idle high |
| txb_evt | output | 1 | One-cycle buffer-sent event |

## Verification
The assertions assume that the host never lets the byte stream run dry within a frame: whenever `in_ready` is high, `in_valid` is already high. They also assume that `cts` stays high from the moment it is granted until `rts` drops. The bench keeps a frame's bytes presented continuously from the start request until the end-of-frame byte is taken. It raises `cts` only after `rts` and clears it only after `rts` has fallen, so stimulus never leaves that envelope.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_FLAG, ST_DATA, ST_FCS, ST_CLOSE, ST_HOLD, ST_DONE
  } tx_state_e;

  localparam int          FLAG_BITS = 8;
  localparam logic [7:0]  FLAG_PAT  = 8'h7E;
  localparam int          FCS_W     = 16;
  localparam logic [15:0] FCS_POLY  = 16'h8408;
  localparam logic [15:0] FCS_INIT  = 16'hFFFF;

  // one serial step of the reflected CRC-16/CCITT
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? FCS_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [FCS_W-1:0] crc_nxt
);
  logic [FCS_W-1:0] crc_q;

  assign crc_nxt = en ? fcs_step(crc_q, din) : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= FCS_INIT;
    else if (clr) crc_q <= FCS_INIT;
    else          crc_q <= crc_nxt;
  end

  // R7: the register is back at its preset while cleared
  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == FCS_INIT)); // R7
endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic count_en,
  input  logic bit_val,
  input  logic stuff_taken,
  output logic stuff_now
);
  localparam int OW = $clog2(RUN + 1);
  logic [OW-1:0] ones_q;

  assign stuff_now = (ones_q == OW'(RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ones_q <= '0;
    else if (clr || stuff_taken)  ones_q <= '0;
    else if (count_en)            ones_q <= bit_val ? ones_q + 1'b1 : '0;
  end

  // R5: a pending stuff bit is always consumed before another bit is counted
  AST_STUFF_BEFORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |-> !count_en); // R5
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int XF_W   = 4,
  parameter int DATA_W = 8,
  parameter int RUN    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XF_W-1:0]   cfg_extra_flags,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_eof,
  output logic              in_ready,
  input  logic              cts,
  output logic              rts,
  output logic              txd,
  output logic              txb_evt
);
  localparam int SH_W  = (FCS_W > DATA_W) ? FCS_W : DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  tx_state_e        state;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] bitcnt_q;
  logic [XF_W-1:0]  flagcnt_q;
  logic             txd_q, rts_q, txb_q, last_q, eof_q;

  // named internal events
  logic             shifting, stuff_now, emit_stuff, adv, unit_end, last_flag;
  logic             in_stuffed_field;
  logic [FCS_W-1:0] crc_nxt;

  assign shifting   = (state == ST_FLAG) || (state == ST_DATA) ||
                      (state == ST_FCS)  || (state == ST_CLOSE);
  assign in_stuffed_field = (state == ST_DATA) || (state == ST_FCS);
  assign emit_stuff = shifting && stuff_now;
  assign adv        = shifting && !stuff_now;
  assign unit_end   = adv && (bitcnt_q == CNT_W'(1));
  assign last_flag  = (flagcnt_q == '0);
  assign in_ready   = unit_end && (((state == ST_FLAG) && last_flag) ||
                                   ((state == ST_DATA) && !eof_q));

  hdlc_tx_stuffer #(.RUN(RUN)) u_stuff (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (!(in_stuffed_field || state == ST_CLOSE)),
    .count_en    (adv && in_stuffed_field),
    .bit_val     (sh_q[0]),
    .stuff_taken (emit_stuff),
    .stuff_now   (stuff_now)
  );

  hdlc_tx_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_FLAG),
    .en      (adv && (state == ST_DATA)),
    .din     (sh_q[0]),
    .crc_nxt (crc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sh_q      <= '0;
      bitcnt_q  <= '0;
      flagcnt_q <= '0;
      txd_q     <= 1'b1;
      rts_q     <= 1'b0;
      txb_q     <= 1'b0;
      last_q    <= 1'b0;
      eof_q     <= 1'b0;
    end else begin
      txb_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          txd_q <= 1'b1;
          if (in_valid) begin
            rts_q <= 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          txd_q <= 1'b1;
          if (cts) begin
            state     <= ST_FLAG;
            sh_q      <= SH_W'(FLAG_PAT);
            bitcnt_q  <= CNT_W'(FLAG_BITS);
            flagcnt_q <= cfg_extra_flags;
          end
        end
        ST_HOLD: begin
          txd_q <= 1'b1;
          state <= ST_DONE;
        end
        ST_DONE: begin
          txd_q <= 1'b1;
          rts_q <= 1'b0;
          state <= ST_IDLE;
        end
        default: begin
          if (emit_stuff) begin
            txd_q <= 1'b0;
          end else begin
            txd_q    <= sh_q[0];
            sh_q     <= sh_q >> 1;
            bitcnt_q <= bitcnt_q - 1'b1;
            if (unit_end) begin
              case (state)
                ST_FLAG: begin
                  if (last_flag) begin
                    sh_q     <= SH_W'(in_data);
                    bitcnt_q <= CNT_W'(DATA_W);
                    last_q   <= in_last;
                    eof_q    <= in_eof;
                    state    <= ST_DATA;
                  end else begin
                    flagcnt_q <= flagcnt_q - 1'b1;
                    sh_q      <= SH_W'(FLAG_PAT);
                    bitcnt_q  <= CNT_W'(FLAG_BITS);
                  end
                end
                ST_DATA: begin
                  txb_q <= last_q || eof_q;
                  if (eof_q) begin
                    sh_q     <= SH_W'(~crc_nxt);
                    bitcnt_q <= CNT_W'(FCS_W);
                    state    <= ST_FCS;
                  end else begin
                    sh_q     <= SH_W'(in_data);
                    bitcnt_q <= CNT_W'(DATA_W);
                    last_q   <= in_last;
                    eof_q    <= in_eof;
                  end
                end
                ST_FCS: begin
                  sh_q     <= SH_W'(FLAG_PAT);
                  bitcnt_q <= CNT_W'(FLAG_BITS);
                  state    <= ST_CLOSE;
                end
                default: state <= ST_HOLD;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign txd     = txd_q;
  assign rts     = rts_q;
  assign txb_evt = txb_q;

  AST_RTS_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> rts_q); // R4
  AST_CTS_GATE:    assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !cts) |=> (state == ST_WAIT)); // R4
  AST_STUFF_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
    emit_stuff |=> !txd_q); // R5
  AST_FLAG_CLEAN:  assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLAG) |-> !stuff_now); // R6
  AST_TXB_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
    txb_q |=> !txb_q); // R3
  AST_IDLE_LINE:   assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> txd_q); // R8
  AST_FEED_OK:     assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R9
endmodule

// File: tb/hdlc_tx_tb.sv
`timescale 1ns/1ps
module hdlc_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_extra_flags = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_eof = 1'b0;
  logic       in_ready;
  logic       cts = 1'b0;
  logic       rts, txd, txb_evt;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  hdlc_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_extra_flags(cfg_extra_flags),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_eof(in_eof),
    .in_ready(in_ready), .cts(cts), .rts(rts), .txd(txd), .txb_evt(txb_evt)
  );

  // frame under test
  logic [7:0] fd [0:15];
  logic       fl [0:15];
  int         nbytes, ptr;
  bit         take;

  // expected line image
  logic       ex_bit [0:1023];
  logic       ex_txb [0:1023];
  logic [3:0] ex_tag [0:1023];
  int         ex_len, ones;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd5: return "R5";
      4'd7: return "R7";
      default: return "R6";
    endcase
  endfunction

  // CRC restated bytewise, reflected, table-free
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic b, input logic [3:0] tg, input logic evt);
    ex_bit[ex_len] = b; ex_txb[ex_len] = evt; ex_tag[ex_len] = tg;
    ex_len++;
  endtask

  task automatic push_stuffed(input logic b, input logic [3:0] tg, input logic evt);
    push(b, tg, evt);
    ones = b ? ones + 1 : 0;
    if (ones == 5) begin push(1'b0, 4'd5, 1'b0); ones = 0; end  // R5
  endtask

  task automatic build(input int extra);
    logic [15:0] c;
    ex_len = 0; ones = 0; c = 16'hFFFF;
    for (int f = 0; f <= extra; f++)
      for (int k = 0; k < 8; k++) push(8'h7E >> k, 4'd1, 1'b0);  // R1
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 0; k < 8; k++)
        push_stuffed(fd[i][k], 4'd2, (k == 7) && fl[i]);          // R2 R3
      c = crc_byte(c, fd[i]);
    end
    c = ~c;
    for (int k = 0; k < 16; k++) push_stuffed(c[k], 4'd7, 1'b0);  // R7
    for (int k = 0; k < 8; k++) push(8'h7E >> k, 4'd6, 1'b0);     // R6 closing
  endtask

  task automatic drive();
    in_valid = (ptr < nbytes);
    in_data  = (ptr < nbytes) ? fd[ptr] : 8'h00;
    in_last  = (ptr < nbytes) ? fl[ptr] : 1'b0;
    in_eof   = (ptr == nbytes - 1);
  endtask

  task automatic tick();
    @(negedge clk);
    if (take) begin ptr++; drive(); end
    take = in_ready;
  endtask

  task automatic run_frame(input int extra, input int cts_delay);
    cfg_extra_flags = 4'(extra);
    build(extra);
    ptr = 0; take = 0;
    drive();
    tick();
    check(rts == 1'b1, "R4", rts, 1);
    for (int d = 0; d < cts_delay; d++) begin
      tick();
      check(txd == 1'b1 && rts == 1'b1, "R4", txd, 1);
    end
    cts = 1'b1;
    tick();
    check(txd == 1'b1, "R4", txd, 1);
    for (int i = 0; i < ex_len; i++) begin
      tick();
      check(txd == ex_bit[i], tag_name(ex_tag[i]), txd, ex_bit[i]);
      check(txb_evt == ex_txb[i], "R3", txb_evt, ex_txb[i]);
    end
    tick();
    check(txd == 1'b1 && rts == 1'b1 && txb_evt == 1'b0, "R8", {txd, rts}, 3);
    tick();
    check(rts == 1'b0 && txd == 1'b1, "R8", {txd, rts}, 2);
    check(ptr == nbytes, "R9", ptr, nbytes);
    cts = 1'b0;
    tick(); tick();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] cv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && rts == 1'b0 && txb_evt == 1'b0 && in_ready == 1'b0,
          "R8", {txd, rts, txb_evt, in_ready}, 8);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 check value of the bench CRC model
    cv = 16'hFFFF;
    for (int i = 0; i < 9; i++) cv = crc_byte(cv, 8'h31 + 8'(i));
    check(~cv == 16'h906E, "R7", ~cv, 16'h906E);

    // directed: long runs of ones, no extra flags (R5)
    nbytes = 2; fd[0] = 8'hFF; fd[1] = 8'hFF; fl[0] = 0; fl[1] = 1;
    run_frame(0, 0);
    // directed: two buffers in one frame, one extra flag (R3, R1)
    nbytes = 3; fd[0] = 8'h03; fd[1] = 8'h3F; fd[2] = 8'h55;
    fl[0] = 1; fl[1] = 0; fl[2] = 1;
    run_frame(1, 3);
    // directed: maximum extra flags, single zero byte
    nbytes = 1; fd[0] = 8'h00; fl[0] = 1;
    run_frame(15, 1);

    // random frames
    for (int f = 0; f < 25; f++) begin
      nbytes = 1 + int'($urandom_range(0, 11));
      for (int i = 0; i < nbytes; i++) begin
        fd[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
        fl[i] = ($urandom_range(0, 2) == 0) || (i == nbytes - 1);
      end
      run_frame(int'($urandom_range(0, 15)), int'($urandom_range(0, 5)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule